// File: doc/BRIEF.md
# Winding Current Chopper with Selectable Decay

This block regulates the current in one motor winding by fixed-period pulse-width chopping. A period counter restarts every `PERIOD_CYC` clocks. At the start of each period the block drives the full bridge so that current rises in the direction given by the setpoint sign. For the first `BLANK_CYC` clocks the block ignores the current comparator, so this window is also the shortest on time.

When the synchronized comparator trip is seen after blanking, the drive stops for the rest of the period and the bridge enters a decay state:
- **Slow decay:** both low sides are on, so the current recirculates.
- **Fast decay:** the polarity is reversed, and the bridge is released once the winding current is reported near zero.
- **Mixed decay:** fast decay first, then slow decay from three quarters of the period onward. Mixed decay applies only while the setpoint magnitude is falling.

Every leg has a break-before-make stage. When a switch turns off, it holds both switches of that leg off for `DEAD_CYC` clocks before the other switch may turn on. The analog comparator and the reference converter sit outside the block. A drive is instanced once per winding.

Top module: `winding_chopper`

## Requirements
- R1: While `rst_n` is low, all four gate outputs are low. After a clock edge that samples `en` low, all four gate outputs are low and the period counter restarts. The first edge that samples `en` high begins a new period, and blanking is counted from that edge.
- R2: At the edge that begins a period, the bridge is set to drive. With `sign_neg`=0, `leg1_hs` and `leg2_ls` are high; with `sign_neg`=1, `leg1_ls` and `leg2_hs` are high. The gates show this one edge after the period-start edge. Gate order in checks is {leg1_hs, leg1_ls, leg2_hs, leg2_ls}.
- R3: If `mag_zero` is high at the period-start edge, all gates stay low for that period.
- R4: A trip seen at an edge whose period count is below `BLANK_CYC` has no effect. A trip held from the period start ends the drive at the edge with count `BLANK_CYC`.
- R5: Once decay has begun, drive is not restored before the next period start, even if the trip is removed.
- R6: Slow decay turns on both low sides, `leg1_ls` and `leg2_ls`, with both high sides off.
- R7: Fast decay drives the polarity opposite to the drive phase. A `near_zero` seen during fast decay turns all gates off for the rest of the period.
- R8: In mixed decay with `falling`=1, a trip before count 3*PERIOD_CYC/4 gives fast decay, which changes to slow decay at the edge with that count. With `falling`=0, or a trip at or after that count, slow decay is used at once.
- R9: `decay_sel` encoding: 2'b00 selects slow, 2'b01 selects mixed, and 2'b10 or 2'b11 selects fast.
- R10: After a switch of a leg turns off, neither switch of that leg turns on for `DEAD_CYC` clocks. The high and low sides of a leg are never on together. A drive-to-fast reversal shows all gates low from one to `DEAD_CYC`+1 edges after the decision, and the new pattern one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Chopper enable; low forces all gates off |
| trip | input | 1 | Synchronized current comparator, high when current exceeds the setpoint |
| sign_neg | input | 1 | Setpoint sign, 1 means negative winding current |
| mag_zero | input | 1 | Setpoint magnitude is zero |
| decay_sel | input | 2 | Decay select: 00 slow, 01 mixed, 1x fast |
| falling | input | 1 | Setpoint magnitude is decreasing |
| near_zero | input | 1 | Winding current is close to zero |
| leg1_hs | output | 1 | High-side gate, leg 1 |
| leg1_ls | output | 1 | Low-side gate, leg 1 |
| leg2_hs | output | 1 | High-side gate, leg 2 |
| leg2_ls | output | 1 | Low-side gate, leg 2 |

## Verification
The phase decision is made at the edge whose period count is k. The gates move at edge k+1 when no reversal is involved. A reversal keeps the affected leg off from edge k+1 through edge k+`DEAD_CYC`+1 and turns the new switch on at edge k+`DEAD_CYC`+2. Disable is seen at the gates one edge after `en` is sampled low, and reset clears them at once.

Each vector sets the inputs, enables the block so that the bench knows the period count of every edge, and samples the gates at the falling clock edge after the edge of a chosen count. The sample points are placed either well clear of a transition or exactly on the dead-time boundary.

// File: rtl/chop_pkg.sv
package chop_pkg;
  // Phase of the chopping cycle
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_DRIVE = 2'd1,
    PH_FAST  = 2'd2,
    PH_SLOW  = 2'd3
  } phase_e;

  // Requested / applied state of one half-bridge leg
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

  // Decay select codes (bit 1 set means fast)
  localparam logic [1:0] DK_SLOW  = 2'b00;
  localparam logic [1:0] DK_MIXED = 2'b01;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic period_start,
  output logic blank_done,
  output logic mix_point
);
  localparam int CW = $clog2(PERIOD_CYC);
  localparam logic [CW-1:0] LAST_V  = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC);
  localparam logic [CW-1:0] MIX_V   = CW'((PERIOD_CYC * 3) / 4);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (!en)                cnt_nxt = '0;
    else if (cnt == LAST_V) cnt_nxt = '0;
    else                    cnt_nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign period_start = en && (cnt == '0);
  assign blank_done   = (cnt >= BLANK_V);
  assign mix_point    = (cnt >= MIX_V);

  // R1: disabling restarts the period
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
endmodule

// File: rtl/chop_phase.sv
module chop_phase
  import chop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       period_start,
  input  logic       blank_done,
  input  logic       mix_point,
  input  logic       trip,
  input  logic       mag_zero,
  input  logic [1:0] decay_sel,
  input  logic       falling,
  input  logic       near_zero,
  output phase_e     phase_o
);
  phase_e phase, phase_nxt;
  logic   mix_fast, mix_fast_nxt;

  always_comb begin
    phase_nxt    = phase;
    mix_fast_nxt = mix_fast;
    if (!en) begin
      phase_nxt    = PH_OFF;
      mix_fast_nxt = 1'b0;
    end else if (period_start) begin
      phase_nxt    = mag_zero ? PH_OFF : PH_DRIVE;
      mix_fast_nxt = 1'b0;
    end else begin
      case (phase)
        PH_DRIVE: begin
          if (trip && blank_done) begin
            if (decay_sel[1]) begin
              phase_nxt = PH_FAST;
            end else if (decay_sel == DK_MIXED && falling && !mix_point) begin
              phase_nxt    = PH_FAST;
              mix_fast_nxt = 1'b1;
            end else begin
              phase_nxt = PH_SLOW;
            end
          end
        end
        PH_FAST: begin
          if (near_zero)                 phase_nxt = PH_OFF;
          else if (mix_fast && mix_point) phase_nxt = PH_SLOW;
        end
        default: phase_nxt = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OFF;
      mix_fast <= 1'b0;
    end else begin
      phase    <= phase_nxt;
      mix_fast <= mix_fast_nxt;
    end
  end

  assign phase_o = phase;

  // R3: zero setpoint keeps the bridge off
  a_r3_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && mag_zero) |=> (phase == PH_OFF));
  // R4: comparator ignored inside the blanking window
  a_r4_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_start && phase == PH_DRIVE && !blank_done) |=> (phase == PH_DRIVE));
  // R5: no return to drive inside a period
  a_r5_no_redrive: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_start && phase != PH_DRIVE) |=> (phase != PH_DRIVE));
  // R7: fast decay releases at zero current
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_start && phase == PH_FAST && near_zero) |=> (phase == PH_OFF));
endmodule

// File: rtl/chop_leg.sv
module chop_leg
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_e req_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

  leg_e          cur, cur_nxt;
  logic [DW-1:0] dcnt, dcnt_nxt;

  always_comb begin
    cur_nxt  = cur;
    dcnt_nxt = (dcnt != '0) ? dcnt - DW'(1) : '0;
    if (req_i != cur) begin
      if (cur != LEG_OFF) begin
        cur_nxt  = LEG_OFF;
        dcnt_nxt = DEAD_V;
      end else if (dcnt == '0) begin
        cur_nxt = req_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= LEG_OFF;
      dcnt <= '0;
    end else begin
      cur  <= cur_nxt;
      dcnt <= dcnt_nxt;
    end
  end

  assign hs_o = (cur == LEG_HI);
  assign ls_o = (cur == LEG_LO);

  // Checker: cycles with both switches off, saturating at the dead time
  logic [DW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap <= DEAD_V;
    else if (hs_o || ls_o)   gap <= '0;
    else if (gap != DEAD_V)  gap <= gap + DW'(1);
  end

  // R10: a switch turns on only after a full dead time with the leg off
  a_r10_dead_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> ($past(gap) >= DEAD_V));
  a_r10_dead_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_o) |-> ($past(gap) >= DEAD_V));
endmodule

// File: rtl/winding_chopper.sv
module winding_chopper
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375,
  parameter int DEAD_CYC   = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       trip,
  input  logic       sign_neg,
  input  logic       mag_zero,
  input  logic [1:0] decay_sel,
  input  logic       falling,
  input  logic       near_zero,
  output logic       leg1_hs,
  output logic       leg1_ls,
  output logic       leg2_hs,
  output logic       leg2_ls
);
  localparam int NLEG = 2;

  logic   period_start, blank_done, mix_point;
  phase_e phase;
  logic [NLEG-1:0] hs, ls;

  chop_timer #(.PERIOD_CYC(PERIOD_CYC), .BLANK_CYC(BLANK_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_start(period_start), .blank_done(blank_done), .mix_point(mix_point)
  );

  chop_phase u_phase (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_start(period_start), .blank_done(blank_done), .mix_point(mix_point),
    .trip(trip), .mag_zero(mag_zero), .decay_sel(decay_sel),
    .falling(falling), .near_zero(near_zero), .phase_o(phase)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_e req;
    logic pol;
    always_comb begin
      // leg 2 mirrors leg 1 across the winding
      pol = sign_neg ^ (g == 1);
      req = LEG_OFF;
      if (en) begin
        case (phase)
          PH_DRIVE: req = pol ? LEG_LO : LEG_HI;
          PH_FAST:  req = pol ? LEG_HI : LEG_LO;
          PH_SLOW:  req = LEG_LO;
          default:  req = LEG_OFF;
        endcase
      end
    end

    chop_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n), .req_i(req), .hs_o(hs[g]), .ls_o(ls[g])
    );
  end

  assign leg1_hs = hs[0];
  assign leg1_ls = ls[0];
  assign leg2_hs = hs[1];
  assign leg2_ls = ls[1];

  // R1: disable turns every gate off at the next edge
  a_r1_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(leg1_hs || leg1_ls || leg2_hs || leg2_ls));
endmodule

// File: tb/winding_chopper_tb.sv
`timescale 1ns/1ps
module winding_chopper_tb;
  localparam int P = 200;
  localparam int B = 20;
  localparam int D = 4;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst_n, en, trip, sign_neg, mag_zero, falling, near_zero;
  logic [1:0] decay_sel;
  logic leg1_hs, leg1_ls, leg2_hs, leg2_ls;

  int checks = 0;
  int errors = 0;
  int shoot  = 0;

  always #5 clk = ~clk;

  winding_chopper #(.PERIOD_CYC(P), .BLANK_CYC(B), .DEAD_CYC(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .trip(trip), .sign_neg(sign_neg),
    .mag_zero(mag_zero), .decay_sel(decay_sel), .falling(falling),
    .near_zero(near_zero), .leg1_hs(leg1_hs), .leg1_ls(leg1_ls),
    .leg2_hs(leg2_hs), .leg2_ls(leg2_ls)
  );

  function automatic logic [3:0] gates();
    return {leg1_hs, leg1_ls, leg2_hs, leg2_ls};
  endfunction

  function automatic string rname(input logic [3:0] id);
    case (id)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates actual=%b expected=%b", req, act, exp);
    end
  endtask

  // {req, sign, dsel, fall, mzero, trip_at, trip_len, zero_at, sample, expected}
  // 255 = never / held. Gates {l1h,l1l,l2h,l2l}
  localparam logic [44:0] VEC [NV] = '{
    {4'd1, 1'b0,2'd0,1'b0,1'b0, 8'd255,8'd255,8'd255, 8'd0,   4'b0000}, // R1
    {4'd2, 1'b0,2'd0,1'b0,1'b0, 8'd255,8'd255,8'd255, 8'd1,   4'b1001}, // R2
    {4'd2, 1'b1,2'd0,1'b0,1'b0, 8'd255,8'd255,8'd255, 8'd1,   4'b0110}, // R2
    {4'd3, 1'b0,2'd0,1'b0,1'b1, 8'd255,8'd255,8'd255, 8'd30,  4'b0000}, // R3
    {4'd4, 1'b0,2'd0,1'b0,1'b0, 8'd5,  8'd5,  8'd255, 8'd100, 4'b1001}, // R4
    {4'd4, 1'b0,2'd0,1'b0,1'b0, 8'd0,  8'd255,8'd255, 8'd19,  4'b1001}, // R4
    {4'd4, 1'b0,2'd0,1'b0,1'b0, 8'd0,  8'd255,8'd255, 8'd21,  4'b0001}, // R4
    {4'd6, 1'b0,2'd0,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd70,  4'b0101}, // R6
    {4'd5, 1'b0,2'd0,1'b0,1'b0, 8'd60, 8'd1,  8'd255, 8'd199, 4'b0101}, // R5
    {4'd10,1'b0,2'd2,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd61,  4'b0000}, // R10
    {4'd10,1'b0,2'd2,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd65,  4'b0000}, // R10
    {4'd7, 1'b0,2'd2,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd66,  4'b0110}, // R7
    {4'd7, 1'b1,2'd2,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd70,  4'b1001}, // R7
    {4'd7, 1'b0,2'd2,1'b0,1'b0, 8'd60, 8'd255,8'd100, 8'd100, 4'b0110}, // R7
    {4'd7, 1'b0,2'd2,1'b0,1'b0, 8'd60, 8'd255,8'd100, 8'd101, 4'b0000}, // R7
    {4'd9, 1'b0,2'd3,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd70,  4'b0110}, // R9
    {4'd8, 1'b0,2'd1,1'b1,1'b0, 8'd60, 8'd255,8'd255, 8'd70,  4'b0110}, // R8
    {4'd8, 1'b0,2'd1,1'b1,1'b0, 8'd60, 8'd255,8'd255, 8'd151, 4'b0100}, // R8
    {4'd8, 1'b0,2'd1,1'b1,1'b0, 8'd60, 8'd255,8'd255, 8'd160, 4'b0101}, // R8
    {4'd8, 1'b0,2'd1,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd70,  4'b0101}, // R8
    {4'd8, 1'b0,2'd1,1'b1,1'b0, 8'd170,8'd255,8'd255, 8'd180, 4'b0101}, // R8
    {4'd8, 1'b0,2'd1,1'b1,1'b0, 8'd60, 8'd255,8'd100, 8'd160, 4'b0000}, // R8
    {4'd6, 1'b1,2'd0,1'b0,1'b0, 8'd60, 8'd255,8'd255, 8'd70,  4'b0101}  // R6
  };

  // Shoot-through monitor for R10
  always @(negedge clk)
    if (rst_n === 1'b1 && ((leg1_hs && leg1_ls) || (leg2_hs && leg2_ls))) shoot++;

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t, l, z, s;
    logic [44:0] v;
    rst_n = 1'b0; en = 1'b1; trip = 1'b0; sign_neg = 1'b0; mag_zero = 1'b0;
    decay_sel = 2'b00; falling = 1'b0; near_zero = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset", gates(), 4'b0000);
    en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table: one period per entry
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      en = 1'b0; trip = 1'b0; near_zero = 1'b0;
      sign_neg = v[40]; decay_sel = v[39:38]; falling = v[37]; mag_zero = v[36];
      t = int'(v[35:28]); l = int'(v[27:20]); z = int'(v[19:12]); s = int'(v[11:4]);
      repeat (D + 4) @(negedge clk);
      en = 1'b1;
      for (int k = 0; k < P; k++) begin
        trip = (k >= t) && (l == 255 || k < t + l);
        near_zero = (k >= z);
        @(posedge clk);
        @(negedge clk);
        if (k == s) chk(rname(v[44:41]), gates(), v[3:0]);
      end
      en = 1'b0; trip = 1'b0; near_zero = 1'b0;
    end

    // R1: disable mid-period, then restart of the period on re-enable
    repeat (D + 4) @(negedge clk);
    sign_neg = 1'b0; decay_sel = 2'b00; falling = 1'b0; mag_zero = 1'b0;
    en = 1'b1;
    for (int k = 0; k < 40; k++) begin @(posedge clk); @(negedge clk); end
    chk("R1 driving before disable", gates(), 4'b1001);
    en = 1'b0;
    @(negedge clk);
    chk("R1 disable off", gates(), 4'b0000);
    repeat (D + 4) @(negedge clk);
    trip = 1'b1;
    en = 1'b1;
    for (int k = 0; k < 22; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 19) chk("R1 restart blank", gates(), 4'b1001);
      if (k == 21) chk("R1 restart decay", gates(), 4'b0001);
    end

    // R1: asynchronous reset while driving
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", gates(), 4'b0000);
    en = 1'b0; trip = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R10: leg exclusivity over the whole run
    checks++;
    if (shoot != 0) begin
      errors++;
      $display("FAIL R10: shoot-through cycles actual=%0d expected=0", shoot);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule